// File: doc/BRIEF.md
# Three-Phase Reactive Power Fault Classifier

This block decides, for a protected three-phase line, whether a disturbance lies inside the protected section and which phases it involves. An upstream stage supplies, for every phase, incremental voltage and current phasors from both line ends. These arrive already time-aligned, as signed real and imaginary parts. With them come an incremental differential current magnitude and a pre-fault differential current magnitude for each phase.

The block stays idle until some phase shows a differential current rise larger than half of its pre-fault value. From that sample on, for each phase, it integrates the reactive part of the incremental complex power, summed over the two ends. On every processed sample it compares each phase's integral against the largest integral magnitude among the three phases. A phase whose normalised value lies below minus one half is marked faulty. From the set of faulty phases the block derives:

- an internal-fault flag,
- a multi-phase flag,
- a single-pole-trip flag.

A clear input returns the block to idle with empty integrals.

Top module: `rq_fault_classifier`

## Requirements
- R1: Per phase and per sample, the increment is Vim·Ire − Vre·Iim for the near end plus the same term for the far end. This is the imaginary part of V times conj(I), summed over both ends. The increment is added to that phase's signed integral. A large reactive increment at one end can therefore be cancelled by the other end.
- R2: While idle, a sample starts integration only if some phase has 2·dIdMag > preIdMag (strictly greater). An idle sample that fails this test changes nothing and produces no valid strobe.
- R3: A phase is faulty when 2·Q < −max(|Qa|,|Qb|,|Qc|). The comparison is strict, so Q equal to exactly minus half the maximum is not faulty.
- R4: `internalFault` is 1 when any phase is faulty. When no phase is faulty (external event), `internalFault`, `multiPhase`, `singlePole` and `faultMask` are all 0.
- R5: `multiPhase` is 1 when two or more phases are faulty. `singlePole` is 1 when exactly one phase is faulty.
- R6: While armed, classification is redone on every sample from the running integrals. A fault spreading from one phase to a second therefore grows the mask, and the flags switch from single-pole to multi-phase.
- R7: Every processed sample gives a one-cycle `outValid` pulse. The new results and the pulse appear on the same clock edge that accepts the sample. Once armed, samples are processed whatever their differential currents.
- R8: `clr` or reset empties the integrals, zeroes all results and returns the block to idle, on the next edge. `clr` overrides a sample on the same edge.
- R9: When all three integrals are zero, no phase is faulty.
- `faultMask` bit 0 is phase a, bit 1 is phase b, bit 2 is phase c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear back to idle |
| sampleValid | input | 1 | One phasor sample set is present this cycle |
| vmRe | input | 48 | Near-end incremental voltage, real, 16 bits per phase (a in bits 15:0) |
| vmIm | input | 48 | Near-end incremental voltage, imaginary |
| imRe | input | 48 | Near-end incremental current, real |
| imIm | input | 48 | Near-end incremental current, imaginary |
| vnRe | input | 48 | Far-end incremental voltage, real |
| vnIm | input | 48 | Far-end incremental voltage, imaginary |
| inRe | input | 48 | Far-end incremental current, real |
| inIm | input | 48 | Far-end incremental current, imaginary |
| dIdMag | input | 48 | Incremental differential current magnitude per phase, unsigned |
| preIdMag | input | 48 | Pre-fault differential current magnitude per phase, unsigned |
| armed | output | 1 | Integration running |
| outValid | output | 1 | One-cycle strobe: results updated |
| faultMask | output | 3 | Faulty phases |
| internalFault | output | 1 | At least one faulty phase |
| multiPhase | output | 1 | Two or more faulty phases |
| singlePole | output | 1 | Exactly one faulty phase |

## Verification
Integral, classification and strobe are all registered on the edge that accepts a sample. A sample driven on a falling edge is therefore reflected in the outputs at the following falling edge, and the bench checks there. A clear also acts on the next edge, so its effect is checked one falling edge after `clr` is raised. The valid pulse is checked to drop again one cycle later. The bench keeps its own signed integrals from R1 and recomputes the expected mask and flags after each sample. This covers several sample sequences: both exact thresholds, end cancellation, a spreading fault and a clear in mid-event.

// File: rtl/rqfc_pkg.sv
package rqfc_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } rqfcState_t;

  typedef struct packed {
    logic accEn;
    logic accClr;
  } rqfcCtrl_t;

endpackage

// File: rtl/rqfc_ctrl.sv
module rqfc_ctrl
  import rqfc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  logic      sampleValid,
  input  logic      startHit,
  output rqfcCtrl_t ctrlS,
  output logic      armed
);

  rqfcState_t stateQ;
  rqfcState_t stateD;

  always_comb begin
    ctrlS.accClr = clr;
    ctrlS.accEn  = sampleValid && !clr && ((stateQ == ST_ARMED) || startHit);
    stateD       = stateQ;
    if (clr) begin
      stateD = ST_IDLE;
    end else if (ctrlS.accEn) begin
      stateD = ST_ARMED;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  assign armed = (stateQ == ST_ARMED);

  AST_CLR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    clr |=> !armed); // R8

  AST_NO_START_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!armed && sampleValid && !startHit) |=> !armed); // R2

  AST_ARMED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (armed && !clr) |=> armed); // R6

endmodule

// File: rtl/rqfc_phase_acc.sv
module rqfc_phase_acc #(
  parameter int PH_W  = 16,
  parameter int ACC_W = 48
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    accEn,
  input  logic                    accClr,
  input  logic signed [PH_W-1:0]  vmRe,
  input  logic signed [PH_W-1:0]  vmIm,
  input  logic signed [PH_W-1:0]  imRe,
  input  logic signed [PH_W-1:0]  imIm,
  input  logic signed [PH_W-1:0]  vnRe,
  input  logic signed [PH_W-1:0]  vnIm,
  input  logic signed [PH_W-1:0]  inRe,
  input  logic signed [PH_W-1:0]  inIm,
  output logic signed [ACC_W-1:0] accNext,
  output logic signed [ACC_W-1:0] accQ
);

  localparam int PROD_W = 2 * PH_W;
  localparam int SUM_W  = PROD_W + 2;

  logic signed [PROD_W-1:0] nearImRe;
  logic signed [PROD_W-1:0] nearReIm;
  logic signed [PROD_W-1:0] farImRe;
  logic signed [PROD_W-1:0] farReIm;
  logic signed [SUM_W-1:0]  qInc;

  always_comb begin
    nearImRe = vmIm * imRe;
    nearReIm = vmRe * imIm;
    farImRe  = vnIm * inRe;
    farReIm  = vnRe * inIm;
    qInc     = SUM_W'(nearImRe) - SUM_W'(nearReIm) + SUM_W'(farImRe) - SUM_W'(farReIm);
    accNext  = accQ + ACC_W'(qInc);
  end

  always_ff @(posedge clk) begin
    if (rst || accClr) begin
      accQ <= '0;
    end else if (accEn) begin
      accQ <= accNext;
    end
  end

endmodule

// File: rtl/rqfc_datapath.sv
module rqfc_datapath
  import rqfc_pkg::*;
#(
  parameter int NPH   = 3,
  parameter int PH_W  = 16,
  parameter int MAG_W = 16,
  parameter int ACC_W = 48
) (
  input  logic                 clk,
  input  logic                 rst,
  input  rqfcCtrl_t            ctrlS,
  input  logic [NPH*PH_W-1:0]  vmRe,
  input  logic [NPH*PH_W-1:0]  vmIm,
  input  logic [NPH*PH_W-1:0]  imRe,
  input  logic [NPH*PH_W-1:0]  imIm,
  input  logic [NPH*PH_W-1:0]  vnRe,
  input  logic [NPH*PH_W-1:0]  vnIm,
  input  logic [NPH*PH_W-1:0]  inRe,
  input  logic [NPH*PH_W-1:0]  inIm,
  input  logic [NPH*MAG_W-1:0] dIdMag,
  input  logic [NPH*MAG_W-1:0] preIdMag,
  output logic                 startHit,
  output logic                 outValid,
  output logic [NPH-1:0]       faultMask,
  output logic                 internalFault,
  output logic                 multiPhase,
  output logic                 singlePole
);

  localparam int ABS_W = ACC_W + 1;
  localparam int CMP_W = ACC_W + 2;
  localparam int CNT_W = $clog2(NPH + 1);

  logic signed [ACC_W-1:0] accNext [NPH];
  logic signed [ACC_W-1:0] accQ    [NPH];
  logic [ABS_W-1:0]        absQ    [NPH];
  logic [NPH-1:0]          startVec;
  logic [ABS_W-1:0]        maxAbs;
  logic [NPH-1:0]          maskD;
  logic [CNT_W-1:0]        faultCnt;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    rqfc_phase_acc #(
      .PH_W  (PH_W),
      .ACC_W (ACC_W)
    ) acc_i (
      .clk     (clk),
      .rst     (rst),
      .accEn   (ctrlS.accEn),
      .accClr  (ctrlS.accClr),
      .vmRe    (vmRe[p*PH_W +: PH_W]),
      .vmIm    (vmIm[p*PH_W +: PH_W]),
      .imRe    (imRe[p*PH_W +: PH_W]),
      .imIm    (imIm[p*PH_W +: PH_W]),
      .vnRe    (vnRe[p*PH_W +: PH_W]),
      .vnIm    (vnIm[p*PH_W +: PH_W]),
      .inRe    (inRe[p*PH_W +: PH_W]),
      .inIm    (inIm[p*PH_W +: PH_W]),
      .accNext (accNext[p]),
      .accQ    (accQ[p])
    );

    // start test: dId > pre/2 evaluated as 2*dId > pre
    assign startVec[p] = {dIdMag[p*MAG_W +: MAG_W], 1'b0} > {1'b0, preIdMag[p*MAG_W +: MAG_W]};

    always_comb begin
      if (accNext[p][ACC_W-1]) begin
        absQ[p] = ABS_W'(-ABS_W'(accNext[p]));
      end else begin
        absQ[p] = ABS_W'(accNext[p]);
      end
    end
  end

  assign startHit = |startVec;

  always_comb begin
    maxAbs = '0;
    for (int p = 0; p < NPH; p++) begin
      if (absQ[p] > maxAbs) begin
        maxAbs = absQ[p];
      end
    end
  end

  // coefficient below -1/2 without a divider: 2*Q + max < 0
  always_comb begin
    logic signed [CMP_W-1:0] twiceQ;
    logic signed [CMP_W-1:0] maxExt;
    logic signed [CMP_W-1:0] margin;
    maskD    = '0;
    faultCnt = '0;
    for (int p = 0; p < NPH; p++) begin
      twiceQ   = CMP_W'(accNext[p]) <<< 1;
      maxExt   = $signed(CMP_W'(maxAbs));
      margin   = twiceQ + maxExt;
      maskD[p] = (maxAbs != '0) && margin[CMP_W-1];
      faultCnt = faultCnt + CNT_W'(maskD[p]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctrlS.accClr) begin
      outValid      <= 1'b0;
      faultMask     <= '0;
      internalFault <= 1'b0;
      multiPhase    <= 1'b0;
      singlePole    <= 1'b0;
    end else begin
      outValid <= ctrlS.accEn;
      if (ctrlS.accEn) begin
        faultMask     <= maskD;
        internalFault <= (faultCnt != '0);
        multiPhase    <= (faultCnt > CNT_W'(1));
        singlePole    <= (faultCnt == CNT_W'(1));
      end
    end
  end

  AST_SINGLE_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    singlePole |-> ($countones(faultMask) == 1)); // R5

  AST_MULTI_TWO_PHASES: assert property (@(posedge clk) disable iff (rst)
    multiPhase |-> ($countones(faultMask) >= 2)); // R5

  AST_EXTERNAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    !internalFault |-> (!multiPhase && !singlePole && faultMask == '0)); // R4

  AST_CLEAR_RESULTS: assert property (@(posedge clk) disable iff (rst)
    ctrlS.accClr |=> (!outValid && faultMask == '0 && !internalFault)); // R8

endmodule

// File: rtl/rq_fault_classifier.sv
module rq_fault_classifier
  import rqfc_pkg::*;
#(
  parameter int NPH   = 3,
  parameter int PH_W  = 16,
  parameter int MAG_W = 16,
  parameter int ACC_W = 48
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 sampleValid,
  input  logic [NPH*PH_W-1:0]  vmRe,
  input  logic [NPH*PH_W-1:0]  vmIm,
  input  logic [NPH*PH_W-1:0]  imRe,
  input  logic [NPH*PH_W-1:0]  imIm,
  input  logic [NPH*PH_W-1:0]  vnRe,
  input  logic [NPH*PH_W-1:0]  vnIm,
  input  logic [NPH*PH_W-1:0]  inRe,
  input  logic [NPH*PH_W-1:0]  inIm,
  input  logic [NPH*MAG_W-1:0] dIdMag,
  input  logic [NPH*MAG_W-1:0] preIdMag,
  output logic                 armed,
  output logic                 outValid,
  output logic [NPH-1:0]       faultMask,
  output logic                 internalFault,
  output logic                 multiPhase,
  output logic                 singlePole
);

  rqfcCtrl_t ctrlS;
  logic      startHit;

  rqfc_ctrl ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .clr         (clr),
    .sampleValid (sampleValid),
    .startHit    (startHit),
    .ctrlS       (ctrlS),
    .armed       (armed)
  );

  rqfc_datapath #(
    .NPH   (NPH),
    .PH_W  (PH_W),
    .MAG_W (MAG_W),
    .ACC_W (ACC_W)
  ) dp_i (
    .clk           (clk),
    .rst           (rst),
    .ctrlS         (ctrlS),
    .vmRe          (vmRe),
    .vmIm          (vmIm),
    .imRe          (imRe),
    .imIm          (imIm),
    .vnRe          (vnRe),
    .vnIm          (vnIm),
    .inRe          (inRe),
    .inIm          (inIm),
    .dIdMag        (dIdMag),
    .preIdMag      (preIdMag),
    .startHit      (startHit),
    .outValid      (outValid),
    .faultMask     (faultMask),
    .internalFault (internalFault),
    .multiPhase    (multiPhase),
    .singlePole    (singlePole)
  );

  AST_VALID_WHEN_ARMED: assert property (@(posedge clk) disable iff (rst)
    outValid |-> armed); // R7

endmodule

// File: tb/rq_fault_classifier_tb_top.sv
module rq_fault_classifier_tb_top;

  localparam int NPH  = 3;
  localparam int PH_W = 16;
  localparam int MG_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic sampleValid = 1'b0;
  logic [NPH*PH_W-1:0] vmRe, vmIm, imRe, imIm, vnRe, vnIm, inRe, inIm;
  logic [NPH*MG_W-1:0] dIdMag, preIdMag;
  logic armed, outValid, internalFault, multiPhase, singlePole;
  logic [NPH-1:0] faultMask;

  int km [NPH];
  int kn [NPH];
  int did [NPH];

  // model state
  longint mAcc [NPH];
  bit     mArmed;
  int     checks = 0;
  int     errors = 0;
  bit     done = 0;

  always #10 clk = ~clk;

  // voltages are purely imaginary (100), currents purely real (k): Q = 100*k per end
  for (genvar p = 0; p < NPH; p++) begin : g_drv
    assign vmRe[p*PH_W +: PH_W]   = '0;
    assign vmIm[p*PH_W +: PH_W]   = 16'sd100;
    assign imRe[p*PH_W +: PH_W]   = PH_W'(km[p]);
    assign imIm[p*PH_W +: PH_W]   = '0;
    assign vnRe[p*PH_W +: PH_W]   = '0;
    assign vnIm[p*PH_W +: PH_W]   = 16'sd100;
    assign inRe[p*PH_W +: PH_W]   = PH_W'(kn[p]);
    assign inIm[p*PH_W +: PH_W]   = '0;
    assign dIdMag[p*MG_W +: MG_W] = MG_W'(did[p]);
    assign preIdMag[p*MG_W +: MG_W] = 16'd100;
  end

  rq_fault_classifier dut_i (
    .clk(clk), .rst(rst), .clr(clr), .sampleValid(sampleValid),
    .vmRe(vmRe), .vmIm(vmIm), .imRe(imRe), .imIm(imIm),
    .vnRe(vnRe), .vnIm(vnIm), .inRe(inRe), .inIm(inIm),
    .dIdMag(dIdMag), .preIdMag(preIdMag),
    .armed(armed), .outValid(outValid), .faultMask(faultMask),
    .internalFault(internalFault), .multiPhase(multiPhase), .singlePole(singlePole)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setIn(int a, int b, int c, int na, int nb, int nc, int da, int db, int dc);
    km[0] = a;  km[1] = b;  km[2] = c;
    kn[0] = na; kn[1] = nb; kn[2] = nc;
    did[0] = da; did[1] = db; did[2] = dc;
  endtask

  function automatic int expMask();
    longint mx = 0;
    int m = 0;
    for (int p = 0; p < NPH; p++) begin
      longint a = (mAcc[p] < 0) ? -mAcc[p] : mAcc[p];
      if (a > mx) mx = a;
    end
    for (int p = 0; p < NPH; p++) begin
      if (mx != 0 && 2 * mAcc[p] < -mx) m |= (1 << p);
    end
    return m;
  endfunction

  // one sample, then check outputs at the following falling edge
  task automatic sample(string tag);
    bit startOk = 0;
    bit proc;
    int m;
    int n;
    for (int p = 0; p < NPH; p++) if (2 * did[p] > 100) startOk = 1;
    proc = mArmed || startOk;
    if (proc) begin
      mArmed = 1;
      for (int p = 0; p < NPH; p++) mAcc[p] += 100 * longint'(km[p] + kn[p]);
    end
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    chk({tag, " R7 outValid"}, int'(outValid), int'(proc));
    chk({tag, " R2 armed"}, int'(armed), int'(mArmed));
    if (proc) begin
      m = expMask();
      n = $countones(m);
      chk({tag, " R3 faultMask"}, int'(faultMask), m);
      chk({tag, " R4 internalFault"}, int'(internalFault), int'(n > 0));
      chk({tag, " R5 multiPhase"}, int'(multiPhase), int'(n > 1));
      chk({tag, " R5 singlePole"}, int'(singlePole), int'(n == 1));
    end
  endtask

  task automatic doClear(string tag);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    mArmed = 0;
    for (int p = 0; p < NPH; p++) mAcc[p] = 0;
    chk({tag, " R8 armed after clr"}, int'(armed), 0);
    chk({tag, " R8 mask after clr"}, int'(faultMask), 0);
    chk({tag, " R8 flags after clr"}, int'({internalFault, multiPhase, singlePole, outValid}), 0);
  endtask

  task automatic t_reset();
    chk("reset R8 armed", int'(armed), 0);
    chk("reset R8 outValid", int'(outValid), 0);
    chk("reset R8 mask", int'(faultMask), 0);
    chk("reset R8 internal", int'(internalFault), 0);
  endtask

  task automatic t_noStart();
    setIn(-200, 0, 0, 0, 0, 0, 50, 50, 50); // exactly half: no start
    sample("noStart R2");
    chk("noStart R2 mask", int'(faultMask), 0);
  endtask

  task automatic t_singleA();
    setIn(-200, 10, 10, 0, 0, 0, 51, 0, 0);
    sample("singleA R1");
    setIn(-50, 5, 5, 0, 0, 0, 0, 0, 0); // armed: no start needed
    sample("singleA armed R7");
    @(negedge clk);
    chk("singleA R7 strobe drops", int'(outValid), 0);
    doClear("singleA");
  endtask

  task automatic t_external();
    setIn(200, 150, 180, 0, 0, 0, 0, 90, 0);
    sample("external R4");
    chk("external R4 internal", int'(internalFault), 0);
    doClear("external");
  endtask

  task automatic t_boundary();
    setIn(-100, 200, 0, 0, 0, 0, 80, 0, 0); // 2Q == -max: healthy
    sample("boundaryEq R3");
    chk("boundaryEq R3 a healthy", int'(faultMask[0]), 0);
    doClear("boundaryEq");
    setIn(-101, 200, 0, 0, 0, 0, 80, 0, 0); // just below: faulty
    sample("boundaryLt R3");
    chk("boundaryLt R3 a faulty", int'(faultMask[0]), 1);
    doClear("boundaryLt");
  endtask

  task automatic t_multi();
    setIn(-200, -150, 50, 0, 0, 0, 0, 0, 70);
    sample("multi R5");
    chk("multi R5 mask", int'(faultMask), 3);
    doClear("multi");
  endtask

  task automatic t_zero();
    setIn(0, 0, 0, 0, 0, 0, 60, 60, 60);
    sample("zero R9");
    chk("zero R9 mask", int'(faultMask), 0);
    doClear("zero");
  endtask

  task automatic t_cancel();
    setIn(-200, -60, 0, 300, 0, 0, 70, 0, 0); // a: -200+300=+100 ; b: -60
    sample("cancel R1");
    chk("cancel R1 mask", int'(faultMask), 2);
    doClear("cancel");
  endtask

  task automatic t_evolve();
    for (int i = 0; i < 3; i++) begin
      setIn(-1, 0, 0, 0, 0, 0, (i == 0) ? 90 : 0, 0, 0);
      sample("evolve early R6");
    end
    chk("evolve R6 single", int'(singlePole), 1);
    for (int i = 0; i < 4; i++) begin
      setIn(-1, -1, 0, 0, 0, 0, 0, 0, 0);
      sample("evolve late R6");
    end
    chk("evolve R6 mask grown", int'(faultMask), 3);
    chk("evolve R6 multi", int'(multiPhase), 1);
    doClear("evolve");
    // back to idle: a non-start sample is ignored
    setIn(-500, 0, 0, 0, 0, 0, 10, 10, 10);
    sample("afterClr R8 idle");
    // fresh integrals: only b faulty
    setIn(0, -40, 10, 0, 0, 0, 0, 80, 0);
    sample("afterClr R8 fresh");
    chk("afterClr R8 mask", int'(faultMask), 2);
    doClear("final");
  endtask

  task automatic t_clrWins();
    setIn(-200, 0, 0, 0, 0, 0, 90, 0, 0);
    clr = 1'b1;
    sampleValid = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    sampleValid = 1'b0;
    chk("clrWins R8 outValid", int'(outValid), 0);
    chk("clrWins R8 armed", int'(armed), 0);
  endtask

  initial begin
    for (int p = 0; p < NPH; p++) mAcc[p] = 0;
    mArmed = 0;
    setIn(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_noStart();
    t_singleA();
    t_external();
    t_boundary();
    t_multi();
    t_zero();
    t_cancel();
    t_evolve();
    t_clrWins();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule